// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management-side register agent of an Ethernet physical-layer device. It watches a serial management bus and decodes read and write frames. The bus is a management clock plus one bidirectional data line, split here into a sampled input, a driven output and an output enable. Behind the parser sits a bank of thirty-two 16-bit register addresses. Two of them hold writable configuration. Two report read-only status, including a remote-fault indication that comes in from the link-partner logic. The rest read as zero.

The upper four bits of the device address are fixed by a parameter. A strap input supplies the lowest bit, so two devices can share one bus and one controller. A disable input shuts out all management traffic: the line stays released and the registers keep their values. The block has no stream interface. The data path is the serial line itself, which has no back-pressure, so every port is a plain level.

Top module: `mgmt_serial_slave`

## Requirements
- R1: There are 32 register addresses of 16 bits each. Any address other than 0, 1, 4 and 5 reads as 0x0000, and writes to it are discarded.
- R2: The data line is sampled on the rising clock edge. A valid frame is at least 32 ones, then the start bits 0 and 1, then a 2-bit opcode (binary 10 = read, 01 = write), then a 5-bit device address, a 5-bit register address, 2 turnaround bits and 16 data bits. All fields are sent MSB first.
- R3: While the disable input is high, a frame neither drives the line nor changes any register.
- R4: On a read, the output enable stays low during the first turnaround bit time. The line carries 0 in the second turnaround bit time and then data bits 15 down to 0, one per bit time. The line is released in the bit time after data bit 0.
- R5: A frame is served only if its device address equals the 4-bit parameter followed by the strap input. The default parameter is 0001, so the accepted addresses are 2 and 3. Any other address is ignored completely.
- R6: Bit 13 of register 5 reads as the present level of the remote-fault input. All other bits of register 5 read 0.
- R7: Bit 4 of register 1 goes to 1 on the first rising edge at which the remote-fault input is high. It stays 1 until register 1 is read. After that read it equals the fault input at that moment.
- R8: Register 0 (reset 0x1000) and register 4 (reset 0x01E1) take all 16 written bits. Register 1 reads as the constant 0x7809 with bit 4 replaced by the fault latch. Writes to registers 1 and 5 are discarded.
- R9: A frame with a start pair of 00, an opcode of 11 or 00, or fewer than 32 leading ones causes no drive and no write. The parser then hunts for a new preamble.
- R10: After reset the output enable is low and all registers hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the data line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Sampled level of the data line |
| mgmt_disable | input | 1 | High blocks all management reads and writes |
| addr_strap | input | 1 | Lowest bit of the device address |
| partner_fault | input | 1 | Remote fault reported by the link partner |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | High while the slave drives the data line |

## Verification
If the parser's bit counter or state is wrong, the fault shows on the line within one bit time of the turnaround. Either the output enable rises a bit early or late, or the data comes out shifted. The bench compares the enable and the driven value in every bit time, so this kind of fault is caught immediately. A wrong register value, or a fault latch that cleared at the wrong time, shows up on the next read of that address. Disabled frames, mismatched addresses and malformed frames are each followed by a read, so a register that was wrongly changed is found within one frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [2:0] {
    S_PRE, S_ST1, S_OP, S_DEV, S_REG, S_TA, S_DATA
  } frame_state_e;

  localparam logic [4:0] RA_CTRL = 5'd0;
  localparam logic [4:0] RA_STAT = 5'd1;
  localparam logic [4:0] RA_ADV  = 5'd4;
  localparam logic [4:0] RA_LPA  = 5'd5;
  localparam int STAT_RF_BIT = 4;
  localparam int LPA_RF_BIT  = 13;
endpackage

// File: rtl/mgmt_frame_parser.sv
module mgmt_frame_parser
  import mgmt_pkg::*;
#(
  parameter int         PRE_MIN = 32,
  parameter logic [3:0] DEV_HI  = 4'b0001
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic        mdio_in,
  input  logic        mgmt_disable,
  input  logic        addr_strap,
  input  logic [15:0] rd_data,
  output logic        rd_en,
  output logic [4:0]  rd_addr,
  output logic        wr_en,
  output logic [4:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        mdio_out,
  output logic        mdio_oe
);
  localparam int CW = $clog2(PRE_MIN + 1);

  frame_state_e st_q;
  logic [CW-1:0] ones_q;
  logic [3:0]    bit_q;
  logic [15:0]   sh_q;
  logic [4:0]    reg_q;
  logic          rd_q, hit_q, oe_q, out_q;

  logic [1:0] opc;
  logic [4:0] field5;
  assign opc    = {sh_q[0], mdio_in};
  assign field5 = {sh_q[3:0], mdio_in};

  assign rd_addr = field5;
  assign rd_en   = (st_q == S_REG) && (bit_q == 4'd4) && rd_q && hit_q;
  assign wr_addr = reg_q;
  assign wr_data = {sh_q[14:0], mdio_in};
  assign wr_en   = (st_q == S_DATA) && (bit_q == 4'd15) && !rd_q && hit_q && !mgmt_disable;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_PRE; ones_q <= '0; bit_q <= '0; sh_q <= '0; reg_q <= '0;
      rd_q <= 1'b0; hit_q <= 1'b0; oe_q <= 1'b0; out_q <= 1'b0;
    end else begin
      case (st_q)
        S_PRE: begin
          if (mdio_in) begin
            if (ones_q != CW'(PRE_MIN)) ones_q <= ones_q + CW'(1);
          end else if (ones_q == CW'(PRE_MIN)) begin
            st_q <= S_ST1;
          end else begin
            ones_q <= '0;
          end
        end
        S_ST1: begin
          ones_q <= '0;
          bit_q  <= '0;
          st_q   <= mdio_in ? S_OP : S_PRE;
        end
        S_OP: begin
          sh_q  <= {sh_q[14:0], mdio_in};
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd1) begin
            bit_q <= '0;
            if (opc == 2'b10)      begin rd_q <= 1'b1; st_q <= S_DEV; end
            else if (opc == 2'b01) begin rd_q <= 1'b0; st_q <= S_DEV; end
            else                   st_q <= S_PRE;
          end
        end
        S_DEV: begin
          sh_q  <= {sh_q[14:0], mdio_in};
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd4) begin
            bit_q <= '0;
            hit_q <= (field5 == {DEV_HI, addr_strap}) && !mgmt_disable;
            st_q  <= S_REG;
          end
        end
        S_REG: begin
          sh_q  <= {sh_q[14:0], mdio_in};
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd4) begin
            bit_q <= '0;
            reg_q <= field5;
            if (rd_en) sh_q <= rd_data;
            st_q  <= S_TA;
          end
        end
        S_TA: begin
          bit_q <= bit_q + 4'd1;
          if (bit_q == 4'd0) begin
            if (rd_q && hit_q) begin oe_q <= 1'b1; out_q <= 1'b0; end
          end else begin
            bit_q <= '0;
            st_q  <= S_DATA;
            if (rd_q && hit_q) begin out_q <= sh_q[15]; sh_q <= {sh_q[14:0], 1'b0}; end
          end
        end
        S_DATA: begin
          bit_q <= bit_q + 4'd1;
          if (rd_q) begin out_q <= sh_q[15]; sh_q <= {sh_q[14:0], 1'b0}; end
          else      sh_q <= {sh_q[14:0], mdio_in};
          if (bit_q == 4'd15) begin
            oe_q   <= 1'b0;
            hit_q  <= 1'b0;
            ones_q <= '0;
            bit_q  <= '0;
            st_q   <= S_PRE;
          end
        end
        default: st_q <= S_PRE;
      endcase
    end
  end

  // R4: first turnaround bit time never driven
  a_r4_ta_released: assert property (@(posedge mdc) disable iff (!rst_n)
    (st_q == S_TA && bit_q == 4'd0) |-> !oe_q);
  // R4: line released right after the last data bit
  a_r4_release_after_data: assert property (@(posedge mdc) disable iff (!rst_n)
    (st_q == S_DATA && bit_q == 4'd15) |=> !oe_q);
  // R9: no drive while hunting or decoding the header
  a_r9_quiet_header: assert property (@(posedge mdc) disable iff (!rst_n)
    (st_q != S_TA && st_q != S_DATA) |-> !oe_q);
  // R3: a frame decoded while disabled never drives
  a_r3_disabled_no_drive: assert property (@(posedge mdc) disable iff (!rst_n)
    (st_q == S_DEV && bit_q == 4'd4 && mgmt_disable) |=> !hit_q);
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
  import mgmt_pkg::*;
#(
  parameter logic [15:0] CTRL_RST   = 16'h1000,
  parameter logic [15:0] ADV_RST    = 16'h01E1,
  parameter logic [15:0] STAT_FIXED = 16'h7809
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  logic        partner_fault,
  input  logic        rd_en,
  input  logic [4:0]  rd_addr,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  logic [15:0] ctrl_q, adv_q;
  logic        rf_q;
  logic        stat_read;

  assign stat_read = rd_en && (rd_addr == RA_STAT);

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      adv_q  <= ADV_RST;
      rf_q   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == RA_CTRL) ctrl_q <= wr_data;
      if (wr_en && wr_addr == RA_ADV)  adv_q  <= wr_data;
      rf_q <= partner_fault | (rf_q & ~stat_read);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: rd_data = ctrl_q;
      RA_STAT: begin
        rd_data = STAT_FIXED;
        rd_data[STAT_RF_BIT] = rf_q;
      end
      RA_ADV:  rd_data = adv_q;
      RA_LPA:  rd_data[LPA_RF_BIT] = partner_fault;
      default: rd_data = '0;
    endcase
  end

  a_r7_fault_sets: assert property (@(posedge mdc) disable iff (!rst_n)
    partner_fault |=> rf_q);
  a_r7_fault_holds: assert property (@(posedge mdc) disable iff (!rst_n)
    (rf_q && !stat_read) |=> rf_q);
  a_r8_ctrl_stable: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_en && wr_addr == RA_CTRL) |=> $stable(ctrl_q));
  a_r8_adv_stable: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_en && wr_addr == RA_ADV) |=> $stable(adv_q));
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
  parameter int          PRE_MIN    = 32,
  parameter logic [3:0]  DEV_HI     = 4'b0001,
  parameter logic [15:0] CTRL_RST   = 16'h1000,
  parameter logic [15:0] ADV_RST    = 16'h01E1,
  parameter logic [15:0] STAT_FIXED = 16'h7809
) (
  input  logic mdc,
  input  logic rst_n,
  input  logic mdio_in,
  input  logic mgmt_disable,
  input  logic addr_strap,
  input  logic partner_fault,
  output logic mdio_out,
  output logic mdio_oe
);
  logic        rd_en, wr_en;
  logic [4:0]  rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;

  mgmt_frame_parser #(.PRE_MIN(PRE_MIN), .DEV_HI(DEV_HI)) u_parser (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .mgmt_disable(mgmt_disable),
    .addr_strap(addr_strap), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  mgmt_reg_bank #(.CTRL_RST(CTRL_RST), .ADV_RST(ADV_RST), .STAT_FIXED(STAT_FIXED)) u_bank (
    .mdc(mdc), .rst_n(rst_n), .partner_fault(partner_fault),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  // R3: nothing is committed while management is disabled
  a_r3_no_write_disabled: assert property (@(posedge mdc) disable iff (!rst_n)
    mgmt_disable |-> !wr_en);
  // R10: enable low in the first cycle after reset
  a_r10_reset_quiet: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(rst_n) |-> !mdio_oe);
endmodule

// File: tb/test_mgmt_serial_slave.sv
module test_mgmt_serial_slave;
  localparam logic [3:0]  HI   = 4'b0001;
  localparam logic [15:0] CRST = 16'h1000;
  localparam logic [15:0] ARST = 16'h01E1;
  localparam logic [15:0] STAT = 16'h7809;

  logic mdc = 1'b0, rst_n = 1'b0, mdio_in = 1'b0;
  logic dis = 1'b0, strap = 1'b0, fault = 1'b0;
  logic oe, out;
  int n_cmp = 0, n_bad = 0;

  logic [15:0] ctrl_m = CRST, adv_m = ARST;
  logic rf_m = 1'b0;

  always #4 mdc = ~mdc;

  mgmt_serial_slave #(.PRE_MIN(32), .DEV_HI(HI), .CTRL_RST(CRST), .ADV_RST(ARST),
                      .STAT_FIXED(STAT)) i_mgmt_serial_slave (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .mgmt_disable(dis),
    .addr_strap(strap), .partner_fault(fault), .mdio_out(out), .mdio_oe(oe)
  );

  function automatic logic [15:0] model_read(input logic [4:0] ra);
    logic [15:0] v;
    v = 16'h0000;
    case (ra)
      5'd0: v = ctrl_m;
      5'd1: begin v = STAT; v[4] = rf_m; end
      5'd4: v = adv_m;
      5'd5: v[13] = fault;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

  task automatic step(input logic b, input logic eo, input logic ev, input string tag);
    @(negedge mdc);
    n_cmp++;
    if (oe !== eo || (eo && out !== ev)) begin
      n_bad++;
      $display("FAIL %s: oe,out=%b,%b expected %b,%b", tag, oe, out, eo, ev);
    end
    mdio_in = b;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic frame(input int pre, input logic [1:0] stc, input logic [1:0] op,
                       input logic [4:0] dev, input logic [4:0] ra,
                       input logic [15:0] wd, input string tag);
    logic hit, drv;
    logic [15:0] rv;
    logic [63:0] hdr;
    int hl;
    hit = (stc == 2'b01) && (op == 2'b10 || op == 2'b01) && (pre >= 32)
          && (dev == {HI, strap}) && !dis;
    drv = hit && (op == 2'b10);
    rv  = model_read(ra);
    for (int i = 0; i < pre; i++) step(1'b1, 1'b0, 1'b0, tag);
    hdr = {50'b0, stc, op, dev, ra};
    hl = 14;
    for (int i = hl - 1; i >= 0; i--) step(hdr[i], 1'b0, 1'b0, tag);
    step(1'b1, 1'b0, 1'b0, tag);
    step(op == 2'b01 ? 1'b0 : 1'b1, drv, 1'b0, tag);
    for (int k = 15; k >= 0; k--)
      step(op == 2'b01 ? wd[k] : 1'b1, drv, rv[k], tag);
    idle(2, tag);
    if (hit && op == 2'b01) begin
      if (ra == 5'd0) ctrl_m = wd;
      if (ra == 5'd4) adv_m = wd;
    end
    if (drv && ra == 5'd1) rf_m = fault;
  endtask

  task automatic rd(input logic [4:0] dev, input logic [4:0] ra, input string tag);
    frame(32, 2'b01, 2'b10, dev, ra, 16'h0, tag);
  endtask
  task automatic wr(input logic [4:0] dev, input logic [4:0] ra, input logic [15:0] d,
                    input string tag);
    frame(32, 2'b01, 2'b01, dev, ra, d, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] me0, me1;
    me0 = {HI, 1'b0};
    me1 = {HI, 1'b1};
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    idle(4, "R10 reset quiet");
    rd(me0, 5'd0, "R10 ctrl reset");
    rd(me0, 5'd4, "R10 adv reset");
    rd(me0, 5'd1, "R8 status constant");
    rd(me0, 5'd5, "R6 lpa idle");
    wr(me0, 5'd0, 16'hA5C3, "R2 write ctrl");
    rd(me0, 5'd0, "R8 ctrl readback");
    wr(me0, 5'd4, 16'h1234, "R8 write adv");
    rd(me0, 5'd4, "R8 adv readback");
    wr(me0, 5'd1, 16'hFFFF, "R8 status write");
    rd(me0, 5'd1, "R8 status unchanged");
    wr(me0, 5'd5, 16'hFFFF, "R8 lpa write");
    rd(me0, 5'd5, "R8 lpa unchanged");
    wr(me0, 5'd7, 16'hBEEF, "R1 unimpl write");
    rd(me0, 5'd7, "R1 unimpl reads zero");
    rd(me0, 5'd31, "R1 reg31 zero");
    rd(me1, 5'd0, "R5 wrong address read");
    wr(me1, 5'd0, 16'h0F0F, "R5 wrong address write");
    rd(me0, 5'd0, "R5 ctrl kept");
    strap = 1'b1;
    idle(2, "R5 strap change");
    rd(me1, 5'd4, "R5 strap address read");
    rd(me0, 5'd4, "R5 old address ignored");
    dis = 1'b1;
    rd(me1, 5'd0, "R3 disabled read");
    wr(me1, 5'd0, 16'h5555, "R3 disabled write");
    dis = 1'b0;
    rd(me1, 5'd0, "R3 ctrl kept");
    fault = 1'b1;
    idle(2, "R7 fault rise");
    rf_m = 1'b1;
    rd(me1, 5'd5, "R6 lpa fault bit");
    rd(me1, 5'd1, "R7 latch set");
    rd(me1, 5'd1, "R7 held while asserted");
    fault = 1'b0;
    idle(2, "R7 fault fall");
    rd(me1, 5'd5, "R6 lpa follows");
    rd(me1, 5'd1, "R7 latched after drop");
    rd(me1, 5'd1, "R7 cleared by read");
    frame(32, 2'b00, 2'b10, me1, 5'd0, 16'h0, "R9 bad start");
    frame(32, 2'b01, 2'b11, me1, 5'd0, 16'h0, "R9 bad opcode 11");
    frame(32, 2'b01, 2'b00, me1, 5'd0, 16'h0, "R9 bad opcode 00");
    frame(31, 2'b01, 2'b10, me1, 5'd0, 16'h0, "R9 short preamble");
    frame(31, 2'b01, 2'b01, me1, 5'd0, 16'h7777, "R9 short preamble write");
    rd(me1, 5'd0, "R9 recovers");
    idle(4, "R4 tail idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule